// File: doc/BRIEF.md
# Time-of-Day Alarm Matcher

This block decides, once per second, whether the current time of day has reached a programmed alarm time. On every second-update strobe it compares the already-advanced seconds, minutes and hours bytes against three alarm bytes. When they match, it sets a sticky alarm flag and emits a one-cycle pulse. If alarm interrupts are enabled and the flag was clear beforehand, it also raises an interrupt request. The time-of-day counter, the calendar and the register bus sit outside the block. They supply the bytes, the strobe and the mode bits, and they acknowledge the flag.

All bytes are decoded before they are compared. The data-mode input chooses between plain binary bytes and packed BCD bytes. The 24-hour input chooses between 24-hour hours and 12-hour hours. In 12-hour form, bit 7 of an hours byte is the PM marker. Any alarm byte whose two top bits are both set is a wildcard. A wildcard matches every value of its field, so an alarm can be made to repeat every second, every minute or every hour. While the divider is held in reset the time does not advance, and no alarm can fire.

Top module: `tod_alarm_match`

## Requirements
- R1: An alarm byte with bits 7 and 6 both 1 is a wildcard and matches any value of its field. The other fields are still compared.
- R2: With `bin_mode` = 1, every time and alarm byte is read as an unsigned binary number.
- R3: With `bin_mode` = 0, every byte is packed BCD. Its value is ten times bits 7:4 plus bits 3:0.
- R4: With `mode_24h` = 0, bit 7 of an hours byte means PM and bits 6:0 hold 1 to 12. This applies to both the time and the alarm. 12 AM compares as hour 0, 12 PM as hour 12, and every other PM hour as the hour plus 12.
- R5: With all three alarm fields wildcarded, every strobe produces a match. With only the seconds field specified, exactly one match occurs per 60 consecutive seconds.
- R6: No match is produced in a cycle where `tick` is low. No match is produced while `div_hold` is high, even if the bytes agree.
- R7: A match in the cycle where `tick` is high drives `af_set` high for exactly the next cycle. It also sets `alarm_flag`, which stays set until `ack`.
- R8: A match sets `irq` only if `alarm_ie` is 1 and `alarm_flag` is clear at that time (or is being acknowledged in the same cycle). A match while the flag is already set leaves `irq` unchanged.
- R9: `ack` clears `alarm_flag` and `irq` on the next clock edge. If a match occurs in the same cycle as `ack`, the match wins: the flag ends set and `irq` follows R8 as if the flag were clear.
- R10: While `rst_n` is low at a clock edge, `af_set`, `alarm_flag` and `irq` are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Second-update strobe; time bytes are already advanced in this cycle |
| div_hold | input | 1 | Divider held in reset; time is frozen, so alarms are blocked |
| bin_mode | input | 1 | 1: bytes are binary; 0: bytes are BCD |
| mode_24h | input | 1 | 1: 24-hour hours; 0: 12-hour hours with bit 7 as PM |
| alarm_ie | input | 1 | Alarm interrupt enable |
| ack | input | 1 | Clears the alarm flag and the interrupt request |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte |
| alm_sec | input | 8 | Alarm seconds byte (wildcard when bits 7:6 = 11) |
| alm_min | input | 8 | Alarm minutes byte (wildcard when bits 7:6 = 11) |
| alm_hour | input | 8 | Alarm hours byte (wildcard when bits 7:6 = 11) |
| af_set | output | 1 | One-cycle pulse after each matching strobe |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq | output | 1 | Alarm interrupt request |

## Verification
A wrong decode shows at the ports on the first strobe whose bytes use the mis-decoded code. An alarm byte that should match produces no `af_set` pulse one cycle later, or a byte that should not match produces one. Sweeping every hour in all four mode combinations exposes a dropped PM bit or a mishandled 12 AM / 12 PM within one strobe of that hour. A wrong flag or interrupt state appears either in the cycle after the offending strobe or `ack`, or one strobe later. In the second case, an already-set flag wrongly suppresses or re-raises `irq`.

// File: rtl/tod_alarm_pkg.sv
// Package: shared widths, byte type and BCD decode for the alarm matcher.
// Assumes time and alarm registers are byte wide with packed BCD nibbles.
package tod_alarm_pkg;
    localparam int TOD_BYTE_W = 8;   // register byte width
    localparam int TOD_FIELDS = 3;   // seconds, minutes, hours
    localparam int TOD_DEC_W  = 9;   // decoded value width (BCD 0x99 -> 99, binary up to 255)

    typedef logic [TOD_BYTE_W-1:0] tod_byte_t;
    typedef logic [TOD_DEC_W-1:0]  tod_val_t;

    // Packed BCD byte to its numeric value: tens nibble * 10 + units nibble.
    function automatic tod_val_t bcd_to_val(input tod_byte_t b);
        return TOD_DEC_W'(b[7:4]) * TOD_DEC_W'(10) + TOD_DEC_W'(b[3:0]);
    endfunction
endpackage

// File: rtl/tod_field_decode.sv
// Module: tod_field_decode
// Turns one register byte into a numeric field value. Binary or BCD is
// chosen by bin_mode. For the hours field (IS_HOUR != 0) in 12-hour form,
// bit 7 is a PM marker and 1..12 is mapped onto 0..23.
// Assumes: wildcard detection is done by the caller on the raw alarm byte.
module tod_field_decode
    import tod_alarm_pkg::*;
#(
    parameter int IS_HOUR = 0
) (
    input  tod_byte_t raw,
    input  logic      bin_mode,
    input  logic      mode_24h,
    output tod_val_t  value
);
    localparam int MSB = TOD_BYTE_W - 1;

    tod_byte_t mag;
    tod_val_t  dec;

    // Strip the PM marker of a 12-hour hours byte, then decode binary or BCD.
    always_comb begin
        mag = raw;
        if (IS_HOUR != 0 && !mode_24h) mag[MSB] = 1'b0;
        dec = bin_mode ? TOD_DEC_W'(mag) : bcd_to_val(mag);
    end

    generate
        if (IS_HOUR != 0) begin : g_hour
            // Map 12-hour form onto 0..23: 12 AM -> 0, 12 PM -> 12, other PM +12.
            always_comb begin
                if (!mode_24h) begin
                    value = (dec == TOD_DEC_W'(12)) ? '0 : dec;
                    if (raw[MSB]) value = value + TOD_DEC_W'(12);
                end else begin
                    value = dec;
                end
            end
        end else begin : g_plain
            assign value = dec;
        end
    endgenerate
endmodule

// File: rtl/tod_alarm_flag.sv
// Module: tod_alarm_flag
// Holds the sticky alarm flag and the interrupt request, and emits the
// one-cycle set pulse. A match in the same cycle as an acknowledge wins.
// Assumes: hit is already qualified by the strobe and by the divider state.
module tod_alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic ack,
    input  logic alarm_ie,
    output logic af_set,
    output logic alarm_flag,
    output logic irq
);
    logic fresh;

    // The flag counts as clear when it is clear or is being acknowledged now.
    assign fresh = !alarm_flag || ack;

    // Update the pulse, the flag and the interrupt request on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            af_set     <= 1'b0;
            alarm_flag <= 1'b0;
            irq        <= 1'b0;
        end else begin
            af_set <= hit;
            if (hit) begin
                alarm_flag <= 1'b1;
                if (alarm_ie && fresh) irq <= 1'b1;
                else if (ack)          irq <= 1'b0;
            end else if (ack) begin
                alarm_flag <= 1'b0;
                irq        <= 1'b0;
            end
        end
    end

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !ack) |=> alarm_flag);
    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hit) |=> (!alarm_flag && !irq));
    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> alarm_flag);
    // R8
    irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(alarm_ie));
endmodule

// File: rtl/tod_alarm_match.sv
// Module: tod_alarm_match (top)
// On each second-update strobe, compares the decoded time fields with the
// decoded alarm fields. Any alarm field may be a wildcard (bits 7:6 = 11).
// A full match, while the divider is running, raises the alarm flag logic.
// Assumes: the time bytes already hold the new second when tick is high.
module tod_alarm_match
    import tod_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       div_hold,
    input  logic       bin_mode,
    input  logic       mode_24h,
    input  logic       alarm_ie,
    input  logic       ack,
    input  logic [7:0] cur_sec,
    input  logic [7:0] cur_min,
    input  logic [7:0] cur_hour,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    output logic       af_set,
    output logic       alarm_flag,
    output logic       irq
);
    localparam int NF  = TOD_FIELDS;
    localparam int MSB = TOD_BYTE_W - 1;

    tod_byte_t       tm_raw [NF];
    tod_byte_t       al_raw [NF];
    tod_val_t        tm_val [NF];
    tod_val_t        al_val [NF];
    logic [NF-1:0]   al_wild;
    logic [NF-1:0]   field_ok;
    logic            hit;

    // Gather the bytes into field order: 0 seconds, 1 minutes, 2 hours.
    always_comb begin
        tm_raw[0] = cur_sec;  tm_raw[1] = cur_min;  tm_raw[2] = cur_hour;
        al_raw[0] = alm_sec;  al_raw[1] = alm_min;  al_raw[2] = alm_hour;
    end

    generate
        for (genvar i = 0; i < NF; i++) begin : g_field
            tod_field_decode #(.IS_HOUR(i == NF - 1 ? 1 : 0)) u_tm_dec (
                .raw(tm_raw[i]), .bin_mode(bin_mode), .mode_24h(mode_24h),
                .value(tm_val[i]));
            tod_field_decode #(.IS_HOUR(i == NF - 1 ? 1 : 0)) u_al_dec (
                .raw(al_raw[i]), .bin_mode(bin_mode), .mode_24h(mode_24h),
                .value(al_val[i]));
            // A field agrees when its alarm byte is a wildcard or the values are equal.
            assign al_wild[i]  = al_raw[i][MSB] & al_raw[i][MSB-1];
            assign field_ok[i] = al_wild[i] || (al_val[i] == tm_val[i]);
        end
    endgenerate

    // A match counts only on a strobe while the time of day is advancing.
    assign hit = tick && !div_hold && (&field_ok);

    tod_alarm_flag u_flag (
        .clk(clk), .rst_n(rst_n), .hit(hit), .ack(ack), .alarm_ie(alarm_ie),
        .af_set(af_set), .alarm_flag(alarm_flag), .irq(irq));

    // R6
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_hold || !tick) |=> !af_set);
    // R5
    all_wild_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !div_hold && (&al_wild)) |=> af_set);
endmodule

// File: tb/tod_alarm_match_bench.sv
// Bench: sweeps hours in all four mode combinations, plus wildcard, hold,
// interrupt and acknowledge scenarios. Expected values come from integer times.
module tod_alarm_match_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, div_hold = 1'b0, bin_mode = 1'b0, mode_24h = 1'b1;
    logic alarm_ie = 1'b0, ack = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0;
    logic [7:0] alm_sec = '0, alm_min = '0, alm_hour = '0;
    logic af_set, alarm_flag, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tod_alarm_match u_tod_alarm_match (
        .clk(clk), .rst_n(rst_n), .tick(tick), .div_hold(div_hold),
        .bin_mode(bin_mode), .mode_24h(mode_24h), .alarm_ie(alarm_ie), .ack(ack),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
        .af_set(af_set), .alarm_flag(alarm_flag), .irq(irq));

    // Encode a number per the current data mode (R2 binary, R3 BCD).
    function automatic logic [7:0] enc(int v);
        if (bin_mode) return 8'(v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    // Encode hour 0..23 per the current hour mode (R4 12-hour with PM in bit 7).
    function automatic logic [7:0] enc_hour(int h);
        int h12;
        if (mode_24h) return enc(h);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return enc(h12) | ((h >= 12) ? 8'h80 : 8'h00);
    endfunction

    task automatic check(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic check3(string req, logic e_set, logic e_af, logic e_irq);
        check(req, "af_set", af_set, e_set);
        check(req, "alarm_flag", alarm_flag, e_af);
        check(req, "irq", irq, e_irq);
    endtask

    // One strobe (optionally with ack); outputs are sampled one cycle later.
    task automatic strobe(logic with_ack);
        @(negedge clk); tick = 1'b1; ack = with_ack;
        @(negedge clk); tick = 1'b0; ack = 1'b0;
    endtask

    task automatic ack_pulse();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic set_time(int h, int m, int s);
        cur_hour = enc_hour(h); cur_min = enc(m); cur_sec = enc(s);
    endtask

    // Strobe from a clear flag, check the outcome, then acknowledge.
    task automatic tick_check(string req, logic exp);
        strobe(1'b0);
        check3(req, exp, exp, exp & alarm_ie);
        ack_pulse();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int fires;
        repeat (3) @(negedge clk);
        // R10 reset state
        check3("R10", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        alarm_ie = 1'b1;

        // R2 R3 R4: every hour in all four mode combinations; 12 AM/PM at h=0,12
        for (int bm = 0; bm < 2; bm++) begin
            for (int md = 0; md < 2; md++) begin
                string tag;
                bin_mode = 1'(bm); mode_24h = 1'(md);
                tag = $sformatf("%s%s", bm ? "R2" : "R3", md ? "" : "/R4");
                for (int h = 0; h < 24; h++) begin
                    set_time(h, 17, 42);
                    alm_min = enc(17); alm_sec = enc(42);
                    alm_hour = enc_hour(h);            tick_check(tag, 1'b1);
                    alm_hour = enc_hour((h + 12) % 24); tick_check(tag, 1'b0);
                    alm_hour = enc_hour((h + 1) % 24);  tick_check(tag, 1'b0);
                end
            end
        end

        // R1 wildcard hour and minute, seconds compared
        bin_mode = 1'b0; mode_24h = 1'b1;
        alm_hour = 8'hC0; alm_min = 8'hFF; alm_sec = enc(25);
        for (int s = 0; s < 60; s++) begin
            set_time(5, 33, s);
            tick_check("R1", s == 25);
        end
        // R1 wildcard minute and second, hour compared
        alm_hour = enc(5); alm_min = 8'hC3; alm_sec = 8'hD0;
        for (int m = 0; m < 60; m += 7) begin
            set_time(5, m, m);         tick_check("R1", 1'b1);
            set_time(6, m, m);         tick_check("R1", 1'b0);
        end

        // R5 all wildcards fire on every strobe
        alm_hour = 8'hC0; alm_min = 8'hC0; alm_sec = 8'hC0;
        for (int t = 0; t < 10; t++) begin
            set_time(t, t * 5, t * 3);
            tick_check("R5", 1'b1);
        end
        // R5 only seconds specified: once per minute over three minutes
        alm_sec = enc(0);
        fires = 0;
        for (int t = 0; t < 180; t++) begin
            set_time(9, t / 60, t % 60);
            strobe(1'b0);
            if (af_set) fires++;
            check3("R5", t % 60 == 0, t % 60 == 0, t % 60 == 0);
            ack_pulse();
        end
        check("R5", "fires per 180 s == 3", fires == 3, 1'b1);

        // R6 matching bytes but no strobe: nothing happens
        set_time(9, 0, 0);
        repeat (4) @(negedge clk);
        check3("R6", 1'b0, 1'b0, 1'b0);
        // R6 divider held: strobe with matching bytes is ignored
        div_hold = 1'b1;
        strobe(1'b0);
        check3("R6", 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check3("R6", 1'b0, 1'b0, 1'b0);
        div_hold = 1'b0;

        // R7 pulse lasts one cycle, flag stays set
        strobe(1'b0);
        check3("R7", 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        check3("R7", 1'b0, 1'b1, 1'b1);
        // R8 second match while flag set keeps irq high
        strobe(1'b0);
        check3("R8", 1'b1, 1'b1, 1'b1);
        // R9 ack clears both
        ack_pulse();
        check3("R9", 1'b0, 1'b0, 1'b0);
        // R8 match with interrupts off: flag only
        alarm_ie = 1'b0;
        strobe(1'b0);
        check3("R8", 1'b1, 1'b1, 1'b0);
        // R8 enable after flag already set: next match does not raise irq
        alarm_ie = 1'b1;
        strobe(1'b0);
        check3("R8", 1'b1, 1'b1, 1'b0);
        // R9 match together with ack: match wins, irq raised as if fresh
        strobe(1'b1);
        check3("R9", 1'b1, 1'b1, 1'b1);
        // R9 non-matching strobe together with ack: cleared
        set_time(9, 0, 1);
        strobe(1'b1);
        check3("R9", 1'b0, 1'b0, 1'b0);

        // R10 reset in the middle clears a set flag
        set_time(9, 0, 0);
        strobe(1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check3("R10", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule